// File: doc/BRIEF.md
# Local Countdown Timer with Programmable Prescaler

This block is a 32-bit countdown timer that sits beside a processor's interrupt controller. Software loads a starting value, picks a clock divider through a small configuration field, and sets a control entry that holds an interrupt vector, a suppress bit and a choice between single-shot and repeating operation. The counter steps down once per prescaled tick. Each time it reaches zero it raises a one-clock request carrying the vector, unless the suppress bit is set.

Register decode happens outside the block: each register arrives as its own write strobe with its data. The live count is driven straight from the counter flops, so a read needs no extra cycle. In repeating mode the count passes through initial+1 values per period, because zero counts as a state of its own before the reload.

Top module: `lct_timer`

## Requirements
- R1: After reset, `cur_count` is 0, `expire_pulse` is 0, the control entry is suppressed and single-shot, and the divider code is 0.
- R2: A divider write keeps only `div_data[3]`, `div_data[1]` and `div_data[0]`, forming code = {div_data[3], div_data[1:0]}; `div_data[2]` has no effect. The tick period is 2^((code+1) mod 8) clocks, so code 7 ticks every clock and code 0 every 2 clocks.
- R3: A start-value write loads `cur_count` on the next clock edge and restarts the prescaler, so the first decrement lands 2^shift edges after the loading edge.
- R4: In single-shot mode (`ent_periodic`=0) the count drops by one per tick, stays at 0, and raises `expire_pulse` exactly once, in the cycle where `cur_count` first reads 0.
- R5: In repeating mode (`ent_periodic`=1), the tick after the count reads 0 reloads the start value. Each arrival at 0 raises `expire_pulse`, which gives one pulse every start+1 ticks.
- R6: With `ent_mask`=1 latched, no `expire_pulse` is raised, and counting goes on unchanged.
- R7: A start value of 0 leaves `cur_count` at 0 and raises no pulse in either mode.
- R8: A control-entry write changes neither the count nor the prescaler phase. The new suppress and mode values govern ticks from the edge after the one that latches them.
- R9: During `expire_pulse`, `expire_vec` equals the `ent_vector` of the latched control entry.
- R10: When a start-value write and an expiring tick fall on the same edge, the write wins: the count takes the new value and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_wr | input | 1 | Divider configuration write strobe |
| div_data | input | 4 | Divider write data (bits 3, 1, 0 used) |
| init_wr | input | 1 | Start-value write strobe |
| init_data | input | 32 | Start value |
| ent_wr | input | 1 | Control-entry write strobe |
| ent_mask | input | 1 | Suppress expiry request |
| ent_periodic | input | 1 | 1 = repeating, 0 = single-shot |
| ent_vector | input | 8 | Vector reported on expiry |
| cur_count | output | 32 | Live counter value |
| expire_pulse | output | 1 | One-clock expiry request |
| expire_vec | output | 8 | Vector of the latest request |

## Verification
A start-value write can land on the same edge as the tick that would carry the count from 1 to 0. The bench sets divider code 7 so that every clock is a tick, and places the second write on exactly that edge. It then expects the new count and no pulse. A control-entry write that arrives partway through a repeating run also competes with an ongoing tick. The bench works out which pulses fall before and after the suppress bit takes hold, and checks that no count value is disturbed.

// File: rtl/lct_pkg.sv
package lct_pkg;

    localparam int LCT_CODE_W = 3;

    typedef logic [LCT_CODE_W-1:0] lct_code_t;

    // Pack the scattered divider bits (3,1,0) into a contiguous code.
    function automatic lct_code_t lct_div_code(input logic [3:0] raw);
        return {raw[3], raw[1:0]};
    endfunction

    // Prescale shift: code + 1, wrapping at the code width.
    function automatic lct_code_t lct_shift(input lct_code_t code);
        return code + 1'b1;
    endfunction

endpackage

// File: rtl/lct_prescale.sv
module lct_prescale
    import lct_pkg::*;
#(
    parameter int CODE_W = LCT_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [CODE_W-1:0] shift,
    output logic              tick
);
    localparam int PRE_W = (1 << CODE_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] limit;

    always_comb begin
        span  = (PRE_W+1)'(1) << shift;
        limit = PRE_W'(span - (PRE_W+1)'(1));
        tick  = (st_q.pre >= limit);
        st_d  = st_q;
        if (restart || tick) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lct_count.sv
module lct_count #(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             periodic,
    input  logic             mask,
    input  logic [VEC_W-1:0] vector,
    output logic [CNT_W-1:0] count,
    output logic             pulse,
    output logic [VEC_W-1:0] vec
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] reload;
        logic             pulse;
        logic [VEC_W-1:0] vec;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (load) begin
            st_d.cnt    = load_val;
            st_d.reload = load_val;
        end else if (tick) begin
            if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
                if ((st_q.cnt == CNT_W'(1)) && !mask) begin
                    st_d.pulse = 1'b1;
                    st_d.vec   = vector;
                end
            end else if (periodic) begin
                st_d.cnt = st_q.reload;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
    assign pulse = st_q.pulse;
    assign vec   = st_q.vec;

endmodule

// File: rtl/lct_timer.sv
module lct_timer
    import lct_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [3:0]       div_data,
    input  logic             init_wr,
    input  logic [CNT_W-1:0] init_data,
    input  logic             ent_wr,
    input  logic             ent_mask,
    input  logic             ent_periodic,
    input  logic [VEC_W-1:0] ent_vector,
    output logic [CNT_W-1:0] cur_count,
    output logic             expire_pulse,
    output logic [VEC_W-1:0] expire_vec
);
    typedef struct packed {
        lct_code_t        code;
        logic             mask;
        logic             periodic;
        logic [VEC_W-1:0] vector;
    } cfg_st_t;

    localparam cfg_st_t CFG_RST = '{code: '0, mask: 1'b1, periodic: 1'b0, vector: '0};

    cfg_st_t   cfg_d, cfg_q;
    lct_code_t shift;
    logic      tick;
    logic      ent_mask_q;
    logic      div_unused;

    assign div_unused = div_data[2];

    always_comb begin
        cfg_d = cfg_q;
        if (div_wr) begin
            cfg_d.code = lct_div_code(div_data);
        end
        if (ent_wr) begin
            cfg_d.mask     = ent_mask;
            cfg_d.periodic = ent_periodic;
            cfg_d.vector   = ent_vector;
        end
        shift = lct_shift(cfg_q.code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign ent_mask_q = cfg_q.mask;

    lct_prescale #(.CODE_W(LCT_CODE_W)) i_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (init_wr),
        .shift   (shift),
        .tick    (tick)
    );

    lct_count #(.CNT_W(CNT_W), .VEC_W(VEC_W)) i_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (init_wr),
        .load_val (init_data),
        .tick     (tick),
        .periodic (cfg_q.periodic),
        .mask     (cfg_q.mask),
        .vector   (cfg_q.vector),
        .count    (cur_count),
        .pulse    (expire_pulse),
        .vec      (expire_vec)
    );

endmodule

// File: rtl/lct_timer_chk.sv
module lct_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_wr,
    input logic [CNT_W-1:0] init_data,
    input logic [CNT_W-1:0] cur_count,
    input logic             expire_pulse,
    input logic             ent_mask_q
);
    assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> cur_count == $past(init_data));

    assert_pulse_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire_pulse |-> (cur_count == '0 && $past(cur_count) == CNT_W'(1)));

    assert_no_double_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire_pulse |=> !expire_pulse);

    assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire_pulse |-> !$past(ent_mask_q));

    assert_step_by_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(init_wr) && $past(cur_count) != '0) |->
        (cur_count == $past(cur_count) || cur_count == $past(cur_count) - CNT_W'(1)));

    assert_zero_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_wr && cur_count == '0 && !expire_pulse) |=> !expire_pulse);
endmodule

bind lct_timer lct_timer_chk #(.CNT_W(CNT_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_wr      (init_wr),
    .init_data    (init_data),
    .cur_count    (cur_count),
    .expire_pulse (expire_pulse),
    .ent_mask_q   (ent_mask_q)
);

// File: tb/test_lct_timer.sv
module test_lct_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_wr = 1'b0;
    logic [3:0]  div_data = '0;
    logic        init_wr = 1'b0;
    logic [31:0] init_data = '0;
    logic        ent_wr = 1'b0;
    logic        ent_mask = 1'b0;
    logic        ent_periodic = 1'b0;
    logic [7:0]  ent_vector = '0;
    logic [31:0] cur_count;
    logic        expire_pulse;
    logic [7:0]  expire_vec;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lct_timer i_lct_timer (
        .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_data(div_data),
        .init_wr(init_wr), .init_data(init_data), .ent_wr(ent_wr),
        .ent_mask(ent_mask), .ent_periodic(ent_periodic), .ent_vector(ent_vector),
        .cur_count(cur_count), .expire_pulse(expire_pulse), .expire_vec(expire_vec)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Program divider and entry, load n, then compare every cycle against
    // the arithmetic model. flip_at >= 0 sets the suppress bit mid-run.
    task automatic run(input logic [3:0] dv, input bit per, input bit msk,
                       input int n, input int cyc, input int flip_at, input string req);
        int code  = int'(dv[3]) * 4 + int'(dv[1:0]);
        int shift = (code + 1) % 8;
        int p     = 1 << shift;
        @(negedge clk);
        div_wr = 1'b1; div_data = dv;
        ent_wr = 1'b1; ent_mask = msk; ent_periodic = per; ent_vector = {4'hA, dv};
        @(negedge clk);
        div_wr = 1'b0; ent_wr = 1'b0;
        init_wr = 1'b1; init_data = 32'(n);
        @(negedge clk);
        init_wr = 1'b0;
        for (int k = 0; k < cyc; k++) begin
            int  j = k / p;
            int  exp_cnt;
            bit  at_zero;
            bit  eff_mask = (flip_at >= 0 && k >= flip_at + 2) ? 1'b1 : msk;
            if (per) begin
                exp_cnt = n - (j % (n + 1));
                at_zero = (j > 0) && (j % (n + 1) == n);
            end else begin
                exp_cnt = (j >= n) ? 0 : n - j;
                at_zero = (j == n);
            end
            at_zero = at_zero && (n > 0) && (k % p == 0) && !eff_mask;
            chk({req, " count"}, cur_count, exp_cnt);
            chk({req, " pulse"}, expire_pulse, at_zero);
            if (at_zero) chk("R9 vector", expire_vec, {4'hA, dv});
            ent_wr = 1'b0;
            if (k == flip_at) begin
                ent_wr = 1'b1; ent_mask = 1'b1;
            end
            @(negedge clk);
        end
        ent_wr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 count", cur_count, 0);
        chk("R1 pulse", expire_pulse, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 count after release", cur_count, 0);

        // R2/R3/R4/R5/R9: sweep all divider inputs (bit 2 must not matter)
        for (int dv = 0; dv < 16; dv++) begin
            int p = 1 << (((dv / 8) * 4 + (dv % 4) + 1) % 8);
            run(4'(dv), 1'b0, 1'b0, 3, 4 * p + 8, -1, "R2 R3 R4 oneshot");
            run(4'(dv), 1'b1, 1'b0, 2, 7 * p + 2, -1, "R2 R5 periodic");
        end

        // R6: suppressed, counting continues
        run(4'h0, 1'b1, 1'b1, 3, 40, -1, "R6 masked");
        // R7: zero start value in both modes
        run(4'hB, 1'b1, 1'b0, 0, 20, -1, "R7 zero periodic");
        run(4'hB, 1'b0, 1'b0, 0, 20, -1, "R7 zero oneshot");
        // R8: entry write mid-run keeps count, new mask applies afterwards
        run(4'hB, 1'b1, 1'b0, 4, 30, 7, "R8 entry midrun");
        run(4'h1, 1'b1, 1'b0, 3, 60, 20, "R8 entry midrun div4");

        // R10: start-value write on the edge that would expire
        @(negedge clk);
        div_wr = 1'b1; div_data = 4'hB;
        ent_wr = 1'b1; ent_mask = 1'b0; ent_periodic = 1'b0; ent_vector = 8'h5C;
        @(negedge clk);
        div_wr = 1'b0; ent_wr = 1'b0; init_wr = 1'b1; init_data = 32'd2;
        @(negedge clk);
        init_wr = 1'b0;
        chk("R10 loaded", cur_count, 2);
        @(negedge clk);
        chk("R10 count one", cur_count, 1);
        init_wr = 1'b1; init_data = 32'd7;
        @(negedge clk);
        init_wr = 1'b0;
        chk("R10 new count", cur_count, 7);
        chk("R10 no pulse", expire_pulse, 0);
        @(negedge clk);
        chk("R10 continues", cur_count, 6);
        chk("R3 restart", expire_pulse, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule